// File: doc/BRIEF.md
# Page Register Column Pointer Decoder

This block sits on the device side of a byte-wide flash command bus and keeps track of where sequential byte access starts inside a 528-byte page register. The register has three regions: a first half (bytes 0 to 255), a second half (bytes 256 to 511) and a 16-byte spare area (bytes 512 to 527). Three pointer commands pick the region. The column byte from the first address cycle is added to the base of that region. Each data strobe then steps the column index by one.

Every latched command byte is decoded into an opcode and reported one cycle later. Bytes outside the defined command set are flagged as illegal and leave the pointer untouched. A second-half selection lasts for one data phase only, and the region falls back to the first half when that phase ends. The first-half and spare selections stay until another pointer command arrives. The cell array, program and erase execution, and all timing of the physical bus are outside this block.

The bus events (command cycle, address cycle, data strobe, data-phase end) arrive as plain single-cycle pulses that have already been latched. Nothing here can stall the bus, so the block has no back-pressure and no ready signal.

Top module: `nand_colptr_dec`

## Requirements
- R1: After reset, `col_idx` is 0, `region` is 0 (first half), and `op_valid` and `cmd_illegal` are low.
- R2: Command 00h sets `region` to 0, with base 0. This selection survives any number of `data_end` pulses.
- R3: Command 01h sets `region` to 1, with base 256.
- R4: Command 50h sets `region` to 2, with base 512. In this region only bits 3:0 of the column byte are used.
- R5: The first `addr_valid` cycle after a legal command loads `col_idx` with base plus column, one cycle later. Later address cycles do not change `col_idx`. If the latest command was 60h, the address cycles do not change `col_idx` at all.
- R6: Each `data_strobe` adds 1 to `col_idx`, one cycle later. `col_idx` saturates at 527.
- R7: A `data_end` pulse while `region` is 1 returns `region` to 0. A `data_end` pulse while `region` is 0 or 2 leaves `region` as it is.
- R8: Command FFh sets `region` to 0 and `col_idx` to 0.
- R9: One cycle after each legal command, `op_valid` pulses and `op_code` holds the decoded value:
  - 00h gives 1, 01h gives 2, 50h gives 3, 90h gives 4, FFh gives 5.
  - 80h gives 6, 10h gives 7, 60h gives 8, D0h gives 9, 70h gives 10.
- R10: For any other command byte:
  - `cmd_illegal` pulses one cycle later and `op_valid` stays low.
  - `region` and `col_idx` keep their values.
  - The pending first-address state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte latched this cycle |
| cmd_byte | input | 8 | Command byte |
| addr_valid | input | 1 | Address byte latched this cycle |
| addr_byte | input | 8 | Address byte |
| data_strobe | input | 1 | One data byte transferred |
| data_end | input | 1 | Current data phase finished |
| col_idx | output | 10 | Current byte index into the page register |
| region | output | 2 | Selected region: 0 first half, 1 second half, 2 spare |
| op_valid | output | 1 | Decoded opcode valid (one-cycle pulse) |
| op_code | output | 4 | Decoded opcode |
| cmd_illegal | output | 1 | Undefined command byte seen (one-cycle pulse) |

## Verification
The assertions assume that at most one of `cmd_valid`, `addr_valid` and `data_strobe` is high in any cycle. The saturation and step properties rely on this, and one assertion checks the assumption itself. The bench drives every bus event through its own task, and each task raises a single strobe for exactly one cycle. Under this scheme, two events can never overlap. `data_end` is only pulsed on cycles with no other event.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;

  typedef enum logic [3:0] {
    OP_NONE         = 4'd0,
    OP_PTR_LO       = 4'd1,
    OP_PTR_HI       = 4'd2,
    OP_PTR_SPARE    = 4'd3,
    OP_IDENT        = 4'd4,
    OP_RESET        = 4'd5,
    OP_PROG_SETUP   = 4'd6,
    OP_PROG_GO      = 4'd7,
    OP_ERASE_SETUP  = 4'd8,
    OP_ERASE_GO     = 4'd9,
    OP_STATUS       = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    RGN_LO    = 2'd0,
    RGN_HI    = 2'd1,
    RGN_SPARE = 2'd2
  } region_e;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
  import nand_colptr_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output op_e        op,
  output logic       legal
);
  always_comb begin
    legal = 1'b1;
    case (cmd_byte)
      8'h00:   op = OP_PTR_LO;
      8'h01:   op = OP_PTR_HI;
      8'h50:   op = OP_PTR_SPARE;
      8'h90:   op = OP_IDENT;
      8'hFF:   op = OP_RESET;
      8'h80:   op = OP_PROG_SETUP;
      8'h10:   op = OP_PROG_GO;
      8'h60:   op = OP_ERASE_SETUP;
      8'hD0:   op = OP_ERASE_GO;
      8'h70:   op = OP_STATUS;
      default: begin
        op    = OP_NONE;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/nand_region_ctl.sv
module nand_region_ctl
  import nand_colptr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_valid,
  input  logic    legal,
  input  op_e     op,
  input  logic    data_end,
  output region_e region
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      region <= RGN_LO;
    end else if (cmd_valid && legal) begin
      case (op)
        OP_PTR_LO, OP_RESET: region <= RGN_LO;
        OP_PTR_HI:           region <= RGN_HI;
        OP_PTR_SPARE:        region <= RGN_SPARE;
        default:             region <= region;
      endcase
    end else if (data_end && region == RGN_HI) begin
      region <= RGN_LO;
    end
  end

  AST_HI_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_HI && data_end && !cmd_valid) |=> region == RGN_LO); // R7
  AST_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (region != RGN_HI && data_end && !cmd_valid) |=> $stable(region)); // R7
  AST_ILLEGAL_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !legal) |=> $stable(region)); // R10
endmodule

// File: rtl/nand_col_counter.sv
module nand_col_counter
  import nand_colptr_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter int COL_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             legal,
  input  op_e              op,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic             data_strobe,
  input  region_e          region,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] HI_BASE    = COL_W'(HALF_BYTES);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * HALF_BYTES);
  localparam logic [7:0]       SPARE_MASK = 8'(SPARE_BYTES - 1);

  logic             armed;
  logic             row_only;
  logic [COL_W-1:0] base;
  logic [7:0]       offset;
  logic [COL_W-1:0] load_val;

  always_comb begin
    case (region)
      RGN_HI:    begin base = HI_BASE;    offset = addr_byte; end
      RGN_SPARE: begin base = SPARE_BASE; offset = addr_byte & SPARE_MASK; end
      default:   begin base = '0;         offset = addr_byte; end
    endcase
    load_val = base + COL_W'(offset);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col      <= '0;
      armed    <= 1'b0;
      row_only <= 1'b0;
    end else if (cmd_valid) begin
      if (legal) begin
        armed    <= 1'b1;
        row_only <= (op == OP_ERASE_SETUP);
        if (op == OP_RESET) col <= '0;
      end
    end else if (addr_valid) begin
      armed <= 1'b0;
      if (armed && !row_only) col <= load_val;
    end else if (data_strobe) begin
      if (col != LAST_COL) col <= col + COL_W'(1);
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_COL); // R6
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_strobe && col != LAST_COL) |=> col == $past(col) + COL_W'(1)); // R6
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_strobe && col == LAST_COL) |=> col == LAST_COL); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && legal && op == OP_RESET) |=> col == '0); // R8
  AST_ILLEGAL_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !legal) |=> $stable(col)); // R10
endmodule

// File: rtl/nand_colptr_dec.sv
module nand_colptr_dec
  import nand_colptr_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  localparam int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_valid,
  input  logic [7:0]       addr_byte,
  input  logic             data_strobe,
  input  logic             data_end,
  output logic [COL_W-1:0] col_idx,
  output logic [1:0]       region,
  output logic             op_valid,
  output logic [3:0]       op_code,
  output logic             cmd_illegal
);
  op_e     dec_op;
  logic    dec_legal;
  region_e rgn;

  nand_cmd_decode u_decode (
    .cmd_byte (cmd_byte),
    .op       (dec_op),
    .legal    (dec_legal)
  );

  nand_region_ctl u_region (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .legal     (dec_legal),
    .op        (dec_op),
    .data_end  (data_end),
    .region    (rgn)
  );

  nand_col_counter #(
    .PAGE_BYTES  (PAGE_BYTES),
    .HALF_BYTES  (HALF_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .COL_W       (COL_W)
  ) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .legal       (dec_legal),
    .op          (dec_op),
    .addr_valid  (addr_valid),
    .addr_byte   (addr_byte),
    .data_strobe (data_strobe),
    .region      (rgn),
    .col         (col_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid    <= 1'b0;
      op_code     <= OP_NONE;
      cmd_illegal <= 1'b0;
    end else begin
      op_valid    <= cmd_valid && dec_legal;
      cmd_illegal <= cmd_valid && !dec_legal;
      if (cmd_valid) op_code <= dec_op;
    end
  end

  assign region = rgn;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, addr_valid, data_strobe})); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && cmd_illegal)); // R10
  AST_OP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(cmd_valid)); // R9
endmodule

// File: tb/nand_colptr_dec_bench.sv
`timescale 1ns/1ps
module nand_colptr_dec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, addr_valid = 1'b0, data_strobe = 1'b0, data_end = 1'b0;
  logic [7:0] cmd_byte = '0, addr_byte = '0;
  logic [9:0] col_idx;
  logic [1:0] region;
  logic       op_valid, cmd_illegal;
  logic [3:0] op_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_colptr_dec u_nand_colptr_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_strobe(data_strobe),
    .data_end(data_end), .col_idx(col_idx), .region(region), .op_valid(op_valid),
    .op_code(op_code), .cmd_illegal(cmd_illegal)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R9 opcode table; 0 means undefined (R10)
  function automatic int exp_op(int b);
    case (b)
      8'h00: return 1;  8'h01: return 2;  8'h50: return 3;  8'h90: return 4;
      8'hFF: return 5;  8'h80: return 6;  8'h10: return 7;  8'h60: return 8;
      8'hD0: return 9;  8'h70: return 10; default: return 0;
    endcase
  endfunction

  task automatic send_cmd(int b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = 8'(b);
    @(negedge clk); cmd_valid = 1'b0;
  endtask
  task automatic send_addr(int b);
    @(negedge clk); addr_valid = 1'b1; addr_byte = 8'(b);
    @(negedge clk); addr_valid = 1'b0;
  endtask
  task automatic strobe();
    @(negedge clk); data_strobe = 1'b1;
    @(negedge clk); data_strobe = 1'b0;
  endtask
  task automatic end_phase();
    @(negedge clk); data_end = 1'b1;
    @(negedge clk); data_end = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 col", int'(col_idx), 0);
    chk("R1 region", int'(region), 0);
    chk("R1 op_valid", int'(op_valid), 0);
    chk("R1 illegal", int'(cmd_illegal), 0);

    // Sweep every command byte from a known state: second half, col 261
    for (int b = 0; b < 256; b++) begin
      int eo, er, ec;
      send_cmd(8'h01); send_addr(5);
      eo = exp_op(b);
      send_cmd(b);
      chk("R9 op_valid", int'(op_valid), eo != 0);
      chk("R10 illegal", int'(cmd_illegal), eo == 0);
      if (eo != 0) chk("R9 op_code", int'(op_code), eo);
      er = 1; ec = 261;
      if (b == 8'h00) er = 0;
      if (b == 8'h50) er = 2;
      if (b == 8'hFF) begin er = 0; ec = 0; end
      chk("R2 R3 R4 R8 R10 region", int'(region), er);
      chk("R8 R10 col", int'(col_idx), ec);
    end

    // Sweep every column byte in each region
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 256; c++) begin
        int pc, base, off;
        pc   = (r == 0) ? 8'h00 : (r == 1) ? 8'h01 : 8'h50;
        base = r * 256;
        off  = (r == 2) ? (c % 16) : c;
        send_cmd(pc); send_addr(c);
        chk("R2 R3 R4 R5 load", int'(col_idx), base + off);
      end
    end

    // R5: second address cycle ignored
    send_cmd(8'h00); send_addr(40); send_addr(99);
    chk("R5 second addr", int'(col_idx), 40);
    // R5: erase setup address cycles do not touch col
    send_cmd(8'h60); send_addr(7); send_addr(8);
    chk("R5 erase addr", int'(col_idx), 40);
    // R10: illegal command keeps pending first address
    send_cmd(8'h00); send_cmd(8'h33); send_addr(12);
    chk("R10 armed kept", int'(col_idx), 12);

    // R6: stepping and saturation in spare area
    send_cmd(8'h50); send_addr(8'h1E);
    chk("R4 spare low bits", int'(col_idx), 526);
    strobe();
    chk("R6 step", int'(col_idx), 527);
    strobe(); strobe();
    chk("R6 saturate", int'(col_idx), 527);

    // R6: run across the half boundary
    send_cmd(8'h00); send_addr(250);
    for (int i = 1; i <= 10; i++) begin
      strobe();
      chk("R6 run", int'(col_idx), 250 + i);
    end

    // R7: second half reverts, others persist
    send_cmd(8'h01); send_addr(3); strobe(); end_phase();
    chk("R7 revert", int'(region), 0);
    chk("R7 col kept", int'(col_idx), 260);
    send_cmd(8'h50); end_phase(); end_phase();
    chk("R7 spare persists", int'(region), 2);
    send_cmd(8'h00); end_phase();
    chk("R2 first half persists", int'(region), 0);

    // R8 from saturated state
    send_cmd(8'h50); send_addr(15); strobe();
    send_cmd(8'hFF);
    chk("R8 col", int'(col_idx), 0);
    chk("R8 region", int'(region), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule